// File: doc/BRIEF.md
# Per-Word Fuse Lock Gate

This block sits between a fuse-array sequencer and a register bus. It holds sticky, per-word lock bitmaps: one that blocks reloading a word's shadow copy, one that blocks writing the shadow copy, and one that blocks burning the fuse word. It also holds a bitmap showing which words carry a permanent lock. A small global lock register and a debug-enable register complete the set. The sequencer presents a word index and an operation type. In the same cycle, the gate answers with exactly one of grant or deny.

A second lookup answers whether a non-secure requester may read a given word. Words below a boundary index are always open. Words at or above the boundary are secure, unless their bit in a non-secure grant bitmap has been set. For a permanent-lock operation the block also works out the lock-area address and data pattern that the sequencer must burn. All lock state is set by writing ones and clears only on reset.

Top module: `wlg_top`

## Requirements
- R1: A bus write to a bank of the reload (0x10), shadow-write (0x20), program (0x30) or grant (0x50) bitmaps sets the bits that are 1 in the data. Bank k sits at base+4k and covers words 32k..32k+31. Bits that are 0 leave their word unchanged. A read of the same address returns the bank.
- R2: No bus write clears any lock, grant or permanent bit. Only reset returns them all to zero.
- R3: A reload request (op 0) is denied in the same cycle when the word's reload bit is set. Otherwise it is granted.
- R4: A shadow-write request (op 1) is denied in the same cycle when the word's shadow-write bit is set. Otherwise it is granted.
- R5: A program request (op 2) is denied when any of these is set: the word's program bit, the word's permanent bit, or global bit 4. A permanent-lock request (op 3) is denied only by global bit 4.
- R6: A request with index at or above NUM_WORDS is always denied. With req_valid low, neither grant nor deny is asserted.
- R7: ns_read_ok is 1 for any index below UPPER_BASE. For an index from UPPER_BASE to NUM_WORDS-1 it equals that word's grant bit, and it is 0 for indices beyond NUM_WORDS-1. Grant bits below UPPER_BASE always read as 0.
- R8: The global register (0x00) sets its bits 0, 2 and 4 on write-one. These bits are sticky, and all other bits read 0.
- R9: Once global bit 0 is set, bus writes to the grant bitmap have no effect.
- R10: The debug-enable register (0x04) stores write data bits 10:0 and reads 0 above them. It drives dbg_enable. Once global bit 2 is set, writes to it are ignored.
- R11: The permanent bitmap (0x40) is set only by perm_done with perm_done_idx. Bus writes to it are ignored.
- R12: For a word below UPPER_BASE, perm_lock_addr is idx>>3 and perm_lock_data is 3 shifted left by twice idx[2:0]. For any other word, the address is (idx>>4)+2 and the data is a single 1 at bit idx[3:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Byte address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| req_valid | input | 1 | Sequencer request valid |
| req_op | input | 2 | 0 reload, 1 shadow write, 2 program, 3 permanent lock |
| req_idx | input | IDX_W | Word index of the request |
| req_grant | output | 1 | Request allowed |
| req_deny | output | 1 | Request refused |
| perm_lock_addr | output | IDX_W | Lock-area address for req_idx |
| perm_lock_data | output | 32 | Lock-area data pattern for req_idx |
| perm_done | input | 1 | Sequencer reports a burned permanent lock |
| perm_done_idx | input | IDX_W | Word whose permanent lock was burned |
| ns_idx | input | IDX_W | Word index of a non-secure read query |
| ns_read_ok | output | 1 | Non-secure read allowed |
| dbg_enable | output | 11 | Current debug-enable value |

## Verification
The hardest case to reach is a program request denied by a permanent bit when the word's program-lock bit is clear. Bus writes cannot set a permanent bit, so the bench drives the sequencer's perm_done report for chosen words. It first shows that a bus write to the permanent bank leaves that bank unchanged. It then sweeps every index with the program operation. The grant-bitmap freeze is reached the same way: the global upper lock is set first, then a grant write is attempted and read back.

// File: rtl/wlg_pkg.sv
package wlg_pkg;
    typedef enum logic [1:0] {
        OP_RELOAD   = 2'd0,
        OP_SWRITE   = 2'd1,
        OP_PROGRAM  = 2'd2,
        OP_PERMLOCK = 2'd3
    } wlg_op_e;

    localparam logic [7:0] ADR_GLOBAL = 8'h00;
    localparam logic [7:0] ADR_DEBUG  = 8'h04;
    localparam logic [7:0] ADR_RELOAD = 8'h10;
    localparam logic [7:0] ADR_SWRITE = 8'h20;
    localparam logic [7:0] ADR_PROG   = 8'h30;
    localparam logic [7:0] ADR_PERM   = 8'h40;
    localparam logic [7:0] ADR_GRANT  = 8'h50;

    localparam int GL_UPPER = 0;
    localparam int GL_DEBUG = 2;
    localparam int GL_PROG  = 4;
    localparam int DBG_W    = 11;
endpackage

// File: rtl/wlg_sticky_bank.sv
module wlg_sticky_bank #(
    parameter int             WORDS     = 96,
    parameter int             LOW_LIMIT = 0,
    parameter int             AW        = 8,
    parameter logic [AW-1:0]  BASE      = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [31:0]      wr_data,
    input  logic [WORDS-1:0] hw_set,
    input  logic [AW-1:0]    rd_addr,
    output logic             rd_hit,
    output logic [31:0]      rd_data,
    output logic [WORDS-1:0] bits
);
    localparam int BANKS = (WORDS + 31) / 32;
    localparam int PAD   = BANKS * 32;

    function automatic logic [PAD-1:0] keep_mask();
        logic [PAD-1:0] m;
        for (int i = 0; i < PAD; i++) m[i] = (i >= LOW_LIMIT) && (i < WORDS);
        return m;
    endfunction

    localparam logic [PAD-1:0] KEEP = keep_mask();

    typedef struct packed {
        logic [PAD-1:0] bits;
    } bank_st_t;

    bank_st_t       st_d, st_q;
    logic [PAD-1:0] hw_pad;

    always_comb begin
        hw_pad = '0;
        hw_pad[WORDS-1:0] = hw_set;
        st_d = st_q;
        st_d.bits = st_d.bits | hw_pad;
        for (int b = 0; b < BANKS; b++) begin
            if (wr_en && wr_addr == BASE + AW'(4 * b))
                st_d.bits[b*32 +: 32] = st_d.bits[b*32 +: 32] | wr_data;
        end
        st_d.bits = st_d.bits & KEEP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_hit  = 1'b0;
        rd_data = '0;
        for (int b = 0; b < BANKS; b++) begin
            if (rd_addr == BASE + AW'(4 * b)) begin
                rd_hit  = 1'b1;
                rd_data = st_q.bits[b*32 +: 32];
            end
        end
    end

    assign bits = st_q.bits[WORDS-1:0];

    assert_sticky_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(st_q.bits) & ~st_q.bits) == '0));
endmodule

// File: rtl/wlg_access_gate.sv
module wlg_access_gate
    import wlg_pkg::*;
#(
    parameter int WORDS      = 96,
    parameter int UPPER_BASE = 32,
    parameter int IDX_W      = 7
) (
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic [IDX_W-1:0] req_idx,
    input  logic [WORDS-1:0] reload_bits,
    input  logic [WORDS-1:0] swrite_bits,
    input  logic [WORDS-1:0] prog_bits,
    input  logic [WORDS-1:0] perm_bits,
    input  logic [WORDS-1:0] grant_bits,
    input  logic             global_prog,
    input  logic [IDX_W-1:0] ns_idx,
    output logic             req_grant,
    output logic             req_deny,
    output logic             ns_read_ok
);
    logic             in_rng, ns_rng, locked;
    logic [IDX_W-1:0] sel, ns_sel;
    wlg_op_e          op;

    always_comb begin
        op     = wlg_op_e'(req_op);
        in_rng = int'(req_idx) < WORDS;
        sel    = in_rng ? req_idx : '0;
        unique case (op)
            OP_RELOAD:   locked = reload_bits[sel];
            OP_SWRITE:   locked = swrite_bits[sel];
            OP_PROGRAM:  locked = prog_bits[sel] | perm_bits[sel] | global_prog;
            default:     locked = global_prog;
        endcase
        req_deny  = req_valid && (!in_rng || locked);
        req_grant = req_valid && !req_deny;

        ns_rng = int'(ns_idx) < WORDS;
        ns_sel = ns_rng ? ns_idx : '0;
        if (int'(ns_idx) < UPPER_BASE) ns_read_ok = 1'b1;
        else                           ns_read_ok = ns_rng && grant_bits[ns_sel];
    end
endmodule

// File: rtl/wlg_perm_encode.sv
module wlg_perm_encode #(
    parameter int UPPER_BASE = 32,
    parameter int IDX_W      = 7
) (
    input  logic [IDX_W-1:0] idx,
    output logic [IDX_W-1:0] lock_addr,
    output logic [31:0]      lock_data
);
    always_comb begin
        if (int'(idx) < UPPER_BASE) begin
            lock_addr = idx >> 3;
            lock_data = 32'd3 << {idx[2:0], 1'b0};
        end else begin
            lock_addr = (idx >> 4) + IDX_W'(2);
            lock_data = 32'd1 << idx[3:0];
        end
    end
endmodule

// File: rtl/wlg_top.sv
module wlg_top
    import wlg_pkg::*;
#(
    parameter int NUM_WORDS  = 96,
    parameter int UPPER_BASE = 32,
    parameter int AW         = 8,
    parameter int IDX_W      = $clog2(NUM_WORDS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [AW-1:0]    bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic [IDX_W-1:0] req_idx,
    output logic             req_grant,
    output logic             req_deny,
    output logic [IDX_W-1:0] perm_lock_addr,
    output logic [31:0]      perm_lock_data,
    input  logic             perm_done,
    input  logic [IDX_W-1:0] perm_done_idx,
    input  logic [IDX_W-1:0] ns_idx,
    output logic             ns_read_ok,
    output logic [10:0]      dbg_enable
);
    localparam int NBANK = 5;

    typedef struct packed {
        logic             upper_lk;
        logic             dbg_lk;
        logic             prog_lk;
        logic [DBG_W-1:0] dbg;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (bus_wr && bus_addr == AW'(ADR_GLOBAL)) begin
            ctl_d.upper_lk = ctl_q.upper_lk | bus_wdata[GL_UPPER];
            ctl_d.dbg_lk   = ctl_q.dbg_lk   | bus_wdata[GL_DEBUG];
            ctl_d.prog_lk  = ctl_q.prog_lk  | bus_wdata[GL_PROG];
        end
        if (bus_wr && bus_addr == AW'(ADR_DEBUG) && !ctl_q.dbg_lk)
            ctl_d.dbg = bus_wdata[DBG_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    logic [NUM_WORDS-1:0] perm_hw;
    always_comb begin
        perm_hw = '0;
        for (int i = 0; i < NUM_WORDS; i++)
            perm_hw[i] = perm_done && (int'(perm_done_idx) == i);
    end

    localparam logic [AW-1:0] BASES [NBANK] = '{AW'(ADR_RELOAD), AW'(ADR_SWRITE),
                                                AW'(ADR_PROG), AW'(ADR_PERM), AW'(ADR_GRANT)};

    logic [NUM_WORDS-1:0] bank_bits [NBANK];
    logic [31:0]          bank_rd   [NBANK];
    logic [NBANK-1:0]     bank_hit;

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        localparam bit IS_PERM  = (g == 3);
        localparam bit IS_GRANT = (g == 4);
        logic             wen;
        logic [NUM_WORDS-1:0] hws;
        assign wen = IS_PERM ? 1'b0 : (IS_GRANT ? (bus_wr && !ctl_q.upper_lk) : bus_wr);
        assign hws = IS_PERM ? perm_hw : '0;
        wlg_sticky_bank #(
            .WORDS(NUM_WORDS), .LOW_LIMIT(IS_GRANT ? UPPER_BASE : 0),
            .AW(AW), .BASE(BASES[g])
        ) u_bank (
            .clk(clk), .rst_n(rst_n), .wr_en(wen), .wr_addr(bus_addr),
            .wr_data(bus_wdata), .hw_set(hws), .rd_addr(bus_addr),
            .rd_hit(bank_hit[g]), .rd_data(bank_rd[g]), .bits(bank_bits[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == AW'(ADR_GLOBAL)) begin
            bus_rdata[GL_UPPER] = ctl_q.upper_lk;
            bus_rdata[GL_DEBUG] = ctl_q.dbg_lk;
            bus_rdata[GL_PROG]  = ctl_q.prog_lk;
        end else if (bus_addr == AW'(ADR_DEBUG)) begin
            bus_rdata[DBG_W-1:0] = ctl_q.dbg;
        end
        for (int g = 0; g < NBANK; g++)
            if (bank_hit[g]) bus_rdata = bank_rd[g];
    end

    wlg_access_gate #(.WORDS(NUM_WORDS), .UPPER_BASE(UPPER_BASE), .IDX_W(IDX_W)) u_gate (
        .req_valid(req_valid), .req_op(req_op), .req_idx(req_idx),
        .reload_bits(bank_bits[0]), .swrite_bits(bank_bits[1]),
        .prog_bits(bank_bits[2]), .perm_bits(bank_bits[3]), .grant_bits(bank_bits[4]),
        .global_prog(ctl_q.prog_lk), .ns_idx(ns_idx),
        .req_grant(req_grant), .req_deny(req_deny), .ns_read_ok(ns_read_ok)
    );

    wlg_perm_encode #(.UPPER_BASE(UPPER_BASE), .IDX_W(IDX_W)) u_enc (
        .idx(req_idx), .lock_addr(perm_lock_addr), .lock_data(perm_lock_data)
    );

    assign dbg_enable = ctl_q.dbg;

    assert_global_prog_deny_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op[1] && ctl_q.prog_lk) |-> req_deny);
    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!req_grant && !req_deny));
    assert_one_answer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> $countones({req_grant, req_deny}) == 1);
    assert_lower_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(ns_idx) < UPPER_BASE) |-> ns_read_ok);
    assert_debug_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'(ADR_DEBUG) && ctl_q.dbg_lk) |=> $stable(dbg_enable));
    assert_global_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctl_q.prog_lk) |-> ctl_q.prog_lk);
endmodule

// File: tb/tb_wlg_top.sv
module tb_wlg_top;
    localparam int NW = 96, UB = 32, AW = 8, IW = 7;

    logic          clk = 0, rst_n = 0;
    logic          bus_wr = 0;
    logic [AW-1:0] bus_addr = 0;
    logic [31:0]   bus_wdata = 0, bus_rdata;
    logic          req_valid = 0;
    logic [1:0]    req_op = 0;
    logic [IW-1:0] req_idx = 0, perm_lock_addr, perm_done_idx = 0, ns_idx = 0;
    logic          req_grant, req_deny, perm_done = 0, ns_read_ok;
    logic [31:0]   perm_lock_data;
    logic [10:0]   dbg_enable;

    int checks = 0, failures = 0;
    logic [NW-1:0] m_rel = 0, m_sw = 0, m_prog = 0, m_perm = 0, m_grant = 0;
    logic          m_gprog = 0;

    always #5 clk = ~clk;

    wlg_top dut (.*);

    task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    task automatic bw(logic [7:0] a, logic [31:0] d);
        @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic rd_chk(string r, logic [7:0] a, logic [31:0] exp);
        bus_addr = a; #1; chk(r, bus_rdata, exp);
    endtask

    function automatic logic exp_deny(int op, int i);
        if (i >= NW) return 1;
        case (op)
            0: return m_rel[i];
            1: return m_sw[i];
            2: return m_prog[i] | m_perm[i] | m_gprog;
            default: return m_gprog;
        endcase
    endfunction

    task automatic sweep(string r, int op);
        for (int i = 0; i < 128; i++) begin
            req_valid = 1; req_op = 2'(op); req_idx = 7'(i); #1;
            chk(r, {req_grant, req_deny}, {!exp_deny(op, i), exp_deny(op, i)});
        end
        req_valid = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R2 reset state
        rd_chk("R2", 8'h10, 0); rd_chk("R8", 8'h00, 0); rd_chk("R10", 8'h04, 0);
        #1; chk("R6", {req_grant, req_deny}, 2'b00);
        // R1 R3 reload bitmap
        bw(8'h10, 32'h0000_0011); bw(8'h18, 32'h8000_0001);
        bw(8'h10, 32'h0000_0100);
        m_rel[0] = 1; m_rel[4] = 1; m_rel[8] = 1; m_rel[64] = 1; m_rel[95] = 1;
        bw(8'h10, 32'h0); // R2 zero write keeps bits
        rd_chk("R1", 8'h10, 32'h0000_0111); rd_chk("R1", 8'h18, 32'h8000_0001);
        rd_chk("R2", 8'h10, 32'h0000_0111);
        sweep("R3", 0);
        // R4 shadow write bitmap
        bw(8'h24, 32'h0000_F000); m_sw[44] = 1; m_sw[45] = 1; m_sw[46] = 1; m_sw[47] = 1;
        rd_chk("R1", 8'h24, 32'h0000_F000);
        sweep("R4", 1);
        // R5 R11 program and permanent
        bw(8'h30, 32'h4); m_prog[2] = 1;
        bw(8'h44, 32'hFFFF_FFFF);
        rd_chk("R11", 8'h44, 0);
        @(negedge clk); perm_done = 1; perm_done_idx = 7'd40;
        @(negedge clk); perm_done_idx = 7'd70;
        @(negedge clk); perm_done = 0;
        m_perm[40] = 1; m_perm[70] = 1;
        rd_chk("R11", 8'h44, 32'h0000_0100); rd_chk("R11", 8'h48, 32'h0000_0040);
        sweep("R5", 2); sweep("R5", 3);
        // R6 idle
        req_valid = 0; req_idx = 7'd2; req_op = 2; #1;
        chk("R6", {req_grant, req_deny}, 2'b00);
        // R7 grant bitmap
        bw(8'h50, 32'hFFFF_FFFF); bw(8'h54, 32'h3); bw(8'h58, 32'h1);
        m_grant[32] = 1; m_grant[33] = 1; m_grant[64] = 1;
        rd_chk("R7", 8'h50, 0); rd_chk("R1", 8'h54, 32'h3);
        for (int i = 0; i < 128; i++) begin
            ns_idx = 7'(i); #1;
            chk("R7", ns_read_ok, (i < UB) ? 1 : (i < NW ? m_grant[i] : 0));
        end
        // R9 upper lock freezes grants
        bw(8'h00, 32'h1);
        bw(8'h54, 32'hFFFF_0000);
        rd_chk("R9", 8'h54, 32'h3);
        ns_idx = 7'd60; #1; chk("R9", ns_read_ok, 0);
        // R10 debug
        bw(8'h04, 32'hFFFF_FFFF); rd_chk("R10", 8'h04, 32'h7FF);
        bw(8'h04, 32'h155); rd_chk("R10", 8'h04, 32'h155); chk("R10", dbg_enable, 32'h155);
        bw(8'h00, 32'h4);
        bw(8'h04, 32'h2AA); rd_chk("R10", 8'h04, 32'h155); chk("R10", dbg_enable, 32'h155);
        // R8 global
        bw(8'h00, 32'hFFFF_FFFF); rd_chk("R8", 8'h00, 32'h15);
        bw(8'h00, 32'h0); rd_chk("R8", 8'h00, 32'h15);
        m_gprog = 1;
        sweep("R5", 2); sweep("R5", 3);
        // R12 encoding
        for (int i = 0; i < NW; i++) begin
            req_idx = 7'(i); #1;
            if (i < UB) begin
                chk("R12", 32'(perm_lock_addr), i >> 3);
                chk("R12", perm_lock_data, 32'd3 << (2 * (i % 8)));
            end else begin
                chk("R12", 32'(perm_lock_addr), (i >> 4) + 2);
                chk("R12", perm_lock_data, 32'd1 << (i % 16));
            end
        end
        // R2 reset clears
        @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
        rd_chk("R2", 8'h10, 0); rd_chk("R2", 8'h48, 0); rd_chk("R2", 8'h54, 0);
        rd_chk("R2", 8'h00, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule